// File: doc/BRIEF.md
# Subcycle Data-Gate Strobe Generator

This block runs the timing chain of a small 4-bit processor's instruction cycle. From that chain it derives the write strobe that lets the internal data bus load the scratchpad register file and the instruction-pointer file.

One system clock stands in for the two non-overlapping phases. Successive clock ticks are taken in turn as the first phase and the second phase. Eight subcycles make up an instruction cycle, so the cycle is sixteen ticks long.

The subcycles run in this order: A1, A2, A3, M1, M2, X1, X2, X3. Each subcycle is one first-phase tick followed by one second-phase tick. The subcycle levels change only after a second-phase tick.

The strobe is the OR of three terms:

- the M1 subcycle level;
- the M2 subcycle level;
- the first phase, qualified by a locally held mask.

The M1 and M2 terms carry the second program byte into the pointer or scratchpad. The qualified first-phase term serves writes whose source is inside the core. The mask is made by a NOR of "A3 in second phase" and "M1 in second phase", and is held across the following first-phase tick. It therefore blocks the first phase only during M1 and M2, where the subcycle level already raises the strobe. The result is equal to the plain form "M1 level OR M2 level OR first phase" on every tick.

Top module: `dg_data_gate_gen`

## Requirements
- R1: While `por_clr` is high, `clk1_en`, `clk2_en` and `data_gate` are 0 and `subcycle_oh` is 8'b0000_0001 (A1).
- R2: Out of clear, exactly one of `clk1_en`/`clk2_en` is 1 on every tick. They alternate each tick.
- R3: `subcycle_oh` is one-hot, with bit 0..7 standing for A1, A2, A3, M1, M2, X1, X2, X3. It keeps its value across a first-phase tick and moves to the next bit after a second-phase tick.
- R4: After the second-phase tick of X3 (bit 7), `subcycle_oh` wraps to A1 (bit 0).
- R5: `data_gate` is 1 on both ticks of M1 (bit 3) and M2 (bit 4).
- R6: In the six other subcycles, `data_gate` is 1 on the first-phase tick and 0 on the second-phase tick.
- R7: On every tick out of clear, `data_gate` equals `subcycle_oh[3] | subcycle_oh[4] | clk1_en`.
- R8: When `por_clr` is released, including after a clear raised mid-cycle, the first tick is A1 in the first phase. The full sixteen-tick pattern follows from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; each tick is one phase |
| por_clr | input | 1 | Power-on clear, active high, asynchronous assert |
| clk1_en | output | 1 | High on first-phase ticks |
| clk2_en | output | 1 | High on second-phase ticks |
| subcycle_oh | output | 8 | One-hot subcycle, bit 0 = A1 ... bit 7 = X3 |
| data_gate | output | 1 | Write strobe into the register and pointer files |

## Verification
The bench checks every tick of several full instruction cycles against a sixteen-tick pattern it computes itself. It pays most attention to the first-phase ticks of M1 and M2. There, a mask that was captured on the wrong subcycle (for example A1 in place of A3) or never captured would still leave the strobe high, so the bench also checks the first-phase ticks of A3 and X1 at each side of that window. A mask that is not cleared would drop the strobe on those ticks. The bench also checks the X3-to-A1 wrap, where an off-by-one terminal count would stall or skip a subcycle. It applies a clear in the middle of M1 and checks that the next cycle restarts at A1 in the first phase, not in the second.

// File: rtl/dg_pkg.sv
package dg_pkg;

   typedef enum logic {
      PH_ONE = 1'b0,
      PH_TWO = 1'b1
   } phase_e;

   localparam int unsigned DG_DEF_SUBCYCLES = 8;
   localparam int unsigned DG_DEF_M_FIRST   = 3;

   localparam int unsigned DG_FORM_NOR = 0;
   localparam int unsigned DG_FORM_OR  = 1;

endpackage

// File: rtl/dg_phase_gen.sv
module dg_phase_gen
   import dg_pkg::*;
(
   input  logic clk,
   input  logic por_clr,
   output logic clk1_tick,
   output logic clk2_tick
);

   phase_e ph_q;

   always_ff @(posedge clk or posedge por_clr) begin
      if (por_clr) ph_q <= PH_ONE;
      else         ph_q <= (ph_q == PH_ONE) ? PH_TWO : PH_ONE;
   end

   assign clk1_tick = ~por_clr & (ph_q == PH_ONE);
   assign clk2_tick = ~por_clr & (ph_q == PH_TWO);

   p_phase_one_r2: assert property (@(posedge clk) disable iff (por_clr)
      (clk1_tick ^ clk2_tick))
      else $error("phase strobes not exclusive");

   p_phase_alt_r2: assert property (@(posedge clk) disable iff (por_clr)
      clk1_tick |=> clk2_tick)
      else $error("second phase did not follow first");

   p_clr_quiet_r1: assert property (@(posedge clk)
      por_clr |-> (!clk1_tick && !clk2_tick))
      else $error("phase strobe during clear");

endmodule

// File: rtl/dg_subcycle_seq.sv
module dg_subcycle_seq #(
   parameter int unsigned SC_COUNT = 8
) (
   input  logic                clk,
   input  logic                por_clr,
   input  logic                clk2_tick,
   output logic [SC_COUNT-1:0] sc_oh
);

   localparam int unsigned IDX_W = (SC_COUNT > 1) ? $clog2(SC_COUNT) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SC_COUNT - 1);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or posedge por_clr) begin
      if (por_clr)
         idx_q <= '0;
      else if (clk2_tick)
         idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
   end

   for (genvar i = 0; i < SC_COUNT; i++) begin : g_dec
      assign sc_oh[i] = (idx_q == IDX_W'(i));
   end

   p_onehot_r3: assert property (@(posedge clk) disable iff (por_clr)
      $onehot(sc_oh))
      else $error("subcycle not one-hot");

   p_hold_r3: assert property (@(posedge clk) disable iff (por_clr)
      !clk2_tick |=> $stable(sc_oh))
      else $error("subcycle moved on first phase");

   p_step_r3: assert property (@(posedge clk) disable iff (por_clr)
      (clk2_tick && !sc_oh[SC_COUNT-1]) |=> (sc_oh == ($past(sc_oh) << 1)))
      else $error("subcycle did not step");

   p_wrap_r4: assert property (@(posedge clk) disable iff (por_clr)
      (clk2_tick && sc_oh[SC_COUNT-1]) |=> sc_oh[0])
      else $error("subcycle did not wrap");

endmodule

// File: rtl/dg_mask_latch.sv
module dg_mask_latch (
   input  logic clk,
   input  logic por_clr,
   input  logic clk1_tick,
   input  logic clk2_tick,
   input  logic a3_lvl,
   input  logic m1_lvl,
   input  logic m2_lvl,
   output logic mask_n
);

   logic a32_term;
   logic m12_term;
   logic nor_raw;
   logic mask_q;

   assign a32_term = a3_lvl & clk2_tick;
   assign m12_term = m1_lvl & clk2_tick;
   assign nor_raw  = ~(a32_term | m12_term);

   always_ff @(posedge clk or posedge por_clr) begin
      if (por_clr)        mask_q <= 1'b1;
      else if (clk2_tick) mask_q <= nor_raw;
   end

   assign mask_n = mask_q;

   p_mask_block_r6: assert property (@(posedge clk) disable iff (por_clr)
      (clk1_tick && (m1_lvl || m2_lvl)) |-> !mask_n)
      else $error("mask open during M1/M2 first phase");

   p_mask_open_r6: assert property (@(posedge clk) disable iff (por_clr)
      (clk1_tick && !m1_lvl && !m2_lvl) |-> mask_n)
      else $error("mask closed outside M1/M2");

endmodule

// File: rtl/dg_gate_combine.sv
module dg_gate_combine
   import dg_pkg::*;
#(
   parameter int unsigned GATE_FORM = DG_FORM_NOR
) (
   input  logic clk,
   input  logic por_clr,
   input  logic clk1_tick,
   input  logic m1_lvl,
   input  logic m2_lvl,
   input  logic mask_n,
   output logic data_gate
);

   logic clk1_term;
   logic gate_raw;

   assign clk1_term = clk1_tick & mask_n;

   if (GATE_FORM == DG_FORM_NOR) begin : g_nor
      logic nor3_n;
      assign nor3_n   = ~(m2_lvl | m1_lvl | clk1_term);
      assign gate_raw = ~nor3_n;
   end else begin : g_or
      assign gate_raw = m1_lvl | m2_lvl | clk1_term;
   end

   assign data_gate = ~por_clr & gate_raw;

   p_mgate_r5: assert property (@(posedge clk) disable iff (por_clr)
      (m1_lvl || m2_lvl) |-> data_gate)
      else $error("gate low in M1/M2");

   p_equiv_r7: assert property (@(posedge clk) disable iff (por_clr)
      data_gate == (m1_lvl | m2_lvl | clk1_tick))
      else $error("gate differs from simplified form");

   p_clr_gate_r1: assert property (@(posedge clk)
      por_clr |-> !data_gate)
      else $error("gate high during clear");

endmodule

// File: rtl/dg_data_gate_gen.sv
module dg_data_gate_gen
   import dg_pkg::*;
#(
   parameter int unsigned SC_COUNT  = DG_DEF_SUBCYCLES,
   parameter int unsigned M_FIRST   = DG_DEF_M_FIRST,
   parameter int unsigned GATE_FORM = DG_FORM_NOR
) (
   input  logic                clk,
   input  logic                por_clr,
   output logic                clk1_en,
   output logic                clk2_en,
   output logic [SC_COUNT-1:0] subcycle_oh,
   output logic                data_gate
);

   localparam int unsigned A3_IDX = M_FIRST - 1;
   localparam int unsigned M2_IDX = M_FIRST + 1;

   if (SC_COUNT < 4) begin : g_bad_count
      $error("SC_COUNT must be at least 4");
   end
   if (M_FIRST < 1 || M2_IDX >= SC_COUNT) begin : g_bad_mpos
      $error("M_FIRST must leave room for A3 before and M2 after");
   end
   if (GATE_FORM != DG_FORM_NOR && GATE_FORM != DG_FORM_OR) begin : g_bad_form
      $error("GATE_FORM out of range");
   end

   logic clk1_tick;
   logic clk2_tick;
   logic mask_n;

   dg_phase_gen u_phase (
      .clk       (clk),
      .por_clr   (por_clr),
      .clk1_tick (clk1_tick),
      .clk2_tick (clk2_tick)
   );

   dg_subcycle_seq #(.SC_COUNT(SC_COUNT)) u_seq (
      .clk       (clk),
      .por_clr   (por_clr),
      .clk2_tick (clk2_tick),
      .sc_oh     (subcycle_oh)
   );

   dg_mask_latch u_mask (
      .clk       (clk),
      .por_clr   (por_clr),
      .clk1_tick (clk1_tick),
      .clk2_tick (clk2_tick),
      .a3_lvl    (subcycle_oh[A3_IDX]),
      .m1_lvl    (subcycle_oh[M_FIRST]),
      .m2_lvl    (subcycle_oh[M2_IDX]),
      .mask_n    (mask_n)
   );

   dg_gate_combine #(.GATE_FORM(GATE_FORM)) u_gate (
      .clk       (clk),
      .por_clr   (por_clr),
      .clk1_tick (clk1_tick),
      .m1_lvl    (subcycle_oh[M_FIRST]),
      .m2_lvl    (subcycle_oh[M2_IDX]),
      .mask_n    (mask_n),
      .data_gate (data_gate)
   );

   assign clk1_en = clk1_tick;
   assign clk2_en = clk2_tick;

   p_clr_oh_r1: assert property (@(posedge clk)
      por_clr |-> (subcycle_oh == SC_COUNT'(1)))
      else $error("subcycle not A1 during clear");

   p_restart_r8: assert property (@(posedge clk)
      ($past(por_clr) && !por_clr) |-> (clk1_en && subcycle_oh[0]))
      else $error("restart not at A1 first phase");

endmodule

// File: tb/tb_dg_data_gate_gen.sv
module tb_dg_data_gate_gen;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       por_clr = 1'b1;
   logic       clk1_en;
   logic       clk2_en;
   logic [7:0] subcycle_oh;
   logic       data_gate;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dg_data_gate_gen dut (
      .clk         (clk),
      .por_clr     (por_clr),
      .clk1_en     (clk1_en),
      .clk2_en     (clk2_en),
      .subcycle_oh (subcycle_oh),
      .data_gate   (data_gate)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Expected values for tick k after release of clear.
   task automatic check_tick(input int k);
      int  sc   = (k / 2) % 8;
      bit  ph1  = (k % 2) == 0;
      bit  in_m = (sc == 3) || (sc == 4);
      logic [7:0] exp_oh = 8'b1 << sc;
      check("R2 phase strobes", {30'd0, clk1_en, clk2_en}, {30'd0, ph1, !ph1});
      if (sc == 0 && k >= 16)
         check("R4 wrap to A1", {24'd0, subcycle_oh}, {24'd0, exp_oh});
      else
         check("R3 subcycle", {24'd0, subcycle_oh}, {24'd0, exp_oh});
      if (in_m)
         check("R5 gate in M1/M2", {31'd0, data_gate}, 32'd1);
      else
         check("R6 gate outside M1/M2", {31'd0, data_gate}, {31'd0, ph1});
      check("R7 simplified form", {31'd0, data_gate},
            {31'd0, subcycle_oh[3] | subcycle_oh[4] | clk1_en});
   endtask

   task automatic check_clear(input string tag);
      check({"R1 quiet ", tag}, {29'd0, clk1_en, clk2_en, data_gate}, 32'd0);
      check({"R1 A1 ", tag}, {24'd0, subcycle_oh}, 32'd1);
   endtask

   task automatic t_reset();
      por_clr = 1'b1;
      #1;
      check_clear("init");
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check_clear("held");
      end
   endtask

   task automatic t_release_and_run(input int ticks);
      @(negedge clk);
      por_clr = 1'b0;
      #1;
      check("R8 first tick A1 phase1", {23'd0, clk1_en, subcycle_oh}, {23'd0, 1'b1, 8'd1});
      check_tick(0);
      for (int k = 1; k < ticks; k++) begin
         @(negedge clk);
         check_tick(k);
      end
   endtask

   task automatic t_midcycle_clear();
      // now at last sampled tick; advance until M1 second phase
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (subcycle_oh[3] && clk2_en) break;
      end
      check("R5 reached M1 phase2", {31'd0, data_gate}, 32'd1);
      por_clr = 1'b1;
      #1;
      check_clear("mid M1");
      @(negedge clk);
      check_clear("mid held");
   endtask

   initial begin
      t_reset();
      t_release_and_run(3 * 16 + 5);
      t_midcycle_clear();
      t_release_and_run(2 * 16);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule